// File: doc/BRIEF.md
# Cursor and Light Pen Unit

This block sits beside a raster timing generator. It watches the refresh memory address and the scan-line (row) address that the generator produces. It raises a registered, active-high cursor output when the scan reaches a programmed character address and the row lies in a programmed, contiguous band of scan lines. The cursor is gated by display enable, so it never appears during blanking.

The same block also serves a light pen. It resynchronises the asynchronous pen input and detects the low-to-high transition. On that transition it latches the live refresh address into a light pen register and sets a sticky capture flag. A read strobe from the host side clears the flag. The latched address stays in place until the next capture.

Top module: `cursor_lpen_unit`

## Requirements
- R1: While `rst_n` is low, `cursor` is 0, `lp_flag` is 0 and `lp_addr` is all zeros.
- R2: `cursor` is 1 in the cycle after one in which `disp_en` is 1, `ma` equals `cur_addr`, and `cur_start <= ra <= cur_end` (both bounds inclusive, unsigned).
- R3: `cursor` is 0 in the cycle after any cycle in which `ma` differs from `cur_addr`.
- R4: `cursor` is 0 in the cycle after any cycle in which `ra` is below `cur_start` or above `cur_end`. When `cur_start > cur_end` the band is empty and the cursor never asserts.
- R5: `cursor` is 0 in the cycle after any cycle in which `disp_en` is 0, even if address and row match.
- R6: A low-to-high transition on `lpen` loads `lp_addr` with the value that `ma` has just before the third rising clock edge after the transition. At that same edge `lp_flag` becomes 1.
- R7: A high-to-low transition on `lpen`, or `lpen` held steady, changes neither `lp_addr` nor `lp_flag`.
- R8: `lp_rd` high at a clock edge clears `lp_flag` at that edge and leaves `lp_addr` unchanged. If a capture happens at the same edge, the capture wins and `lp_flag` stays 1.
- R9: The cursor can sit at any address in the full 14-bit range, including 0x0000 and 0x3FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma | input | 14 | Current refresh memory address |
| ra | input | 5 | Current scan-line address within the character row |
| disp_en | input | 1 | Active-display indication from the timing generator |
| cur_addr | input | 14 | Programmed cursor character address |
| cur_start | input | 5 | First scan line of the cursor band |
| cur_end | input | 5 | Last scan line of the cursor band |
| lpen | input | 1 | Asynchronous light pen input, rising edge active |
| lp_rd | input | 1 | Light pen register read strobe; clears the capture flag |
| cursor | output | 1 | Registered cursor output, active high |
| lp_addr | output | 14 | Latched light pen address |
| lp_flag | output | 1 | Sticky capture flag |

## Verification
A wrong match or band decision shows on `cursor` exactly one cycle after the offending address, row or enable value. Each such fault is therefore caught at the next sample. A synchroniser or edge detector in the wrong state shows as a capture of the wrong neighbour address, a capture on a falling edge, or a flag that fails to set. All of these appear within three cycles of a pen transition. A flag-clear fault shows one cycle after the read strobe, and so does the coincident set-versus-clear priority.

// File: rtl/cursor_lpen_unit.sv
module cursor_lpen_unit #(
  parameter int AW = 14,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ma,
  input  logic [RW-1:0] ra,
  input  logic          disp_en,
  input  logic [AW-1:0] cur_addr,
  input  logic [RW-1:0] cur_start,
  input  logic [RW-1:0] cur_end,
  input  logic          lpen,
  input  logic          lp_rd,
  output logic          cursor,
  output logic [AW-1:0] lp_addr,
  output logic          lp_flag
);

  logic [2:0] pen_q;
  logic       addr_hit, row_hit, pen_rise;

  assign addr_hit = (ma == cur_addr);
  assign row_hit  = (ra >= cur_start) && (ra <= cur_end);
  assign pen_rise = pen_q[1] & ~pen_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cursor <= 1'b0;
    else        cursor <= disp_en & addr_hit & row_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pen_q <= '0;
    else        pen_q <= {pen_q[1:0], lpen};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_addr <= '0;
      lp_flag <= 1'b0;
    end else if (pen_rise) begin
      lp_addr <= ma;
      lp_flag <= 1'b1;
    end else if (lp_rd) begin
      lp_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/cursor_lpen_chk.sv
module cursor_lpen_chk #(
  parameter int AW = 14,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ma,
  input logic [RW-1:0] ra,
  input logic          disp_en,
  input logic [AW-1:0] cur_addr,
  input logic [RW-1:0] cur_start,
  input logic [RW-1:0] cur_end,
  input logic          lp_rd,
  input logic          cursor,
  input logic [AW-1:0] lp_addr,
  input logic          lp_flag
);

  assert_cursor_in_display_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cursor |-> $past(disp_en));

  assert_cursor_addr_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cursor |-> $past(ma) == $past(cur_addr));

  assert_cursor_in_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cursor |-> ($past(ra) >= $past(cur_start)) && ($past(ra) <= $past(cur_end)));

  assert_capture_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lp_addr) |-> lp_flag);

  assert_flag_clear_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_flag) |-> $past(lp_rd));

endmodule

bind cursor_lpen_unit cursor_lpen_chk #(.AW(AW), .RW(RW)) u_chk (.*);

// File: tb/tb_cursor_lpen_unit.sv
module tb_cursor_lpen_unit;
  logic        clk = 0, rst_n = 0;
  logic [13:0] ma = 0, cur_addr = 0;
  logic [4:0]  ra = 0, cur_start = 0, cur_end = 0;
  logic        disp_en = 0, lpen = 0, lp_rd = 0;
  logic        cursor, lp_flag;
  logic [13:0] lp_addr;
  int nchk = 0, nbad = 0;

  cursor_lpen_unit dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cur_step(logic [13:0] a, logic [4:0] r, logic de, logic exp, string req);
    @(negedge clk); ma = a; ra = r; disp_en = de;
    @(negedge clk); chk(req, cursor, exp);
  endtask

  task automatic t_reset;
    chk("R1 cursor", cursor, 0); chk("R1 flag", lp_flag, 0); chk("R1 addr", lp_addr, 0);
  endtask

  task automatic t_cursor;
    cur_addr = 14'h0123; cur_start = 5'd3; cur_end = 5'd6;
    cur_step(14'h0123, 5'd4, 1, 1, "R2 mid band");
    cur_step(14'h0123, 5'd3, 1, 1, "R2 start bound");
    cur_step(14'h0123, 5'd6, 1, 1, "R2 end bound");
    cur_step(14'h0124, 5'd4, 1, 0, "R3 addr mismatch");
    cur_step(14'h0122, 5'd4, 1, 0, "R3 addr mismatch low");
    cur_step(14'h0123, 5'd2, 1, 0, "R4 below band");
    cur_step(14'h0123, 5'd7, 1, 0, "R4 above band");
    cur_step(14'h0123, 5'd4, 0, 0, "R5 blanking");
    cur_start = 5'd6; cur_end = 5'd3;
    cur_step(14'h0123, 5'd4, 1, 0, "R4 empty band");
    cur_step(14'h0123, 5'd6, 1, 0, "R4 empty band edge");
    cur_start = 5'd0; cur_end = 5'd31; cur_addr = 14'h0000;
    cur_step(14'h0000, 5'd0, 1, 1, "R9 addr 0");
    cur_addr = 14'h3FFF;
    cur_step(14'h3FFF, 5'd31, 1, 1, "R9 addr 3FFF");
    cur_step(14'h3FFE, 5'd31, 1, 0, "R9 neighbour");
  endtask

  task automatic t_pen;
    disp_en = 0;
    @(negedge clk); lpen = 1; ma = 14'h0A00;
    @(negedge clk); ma = 14'h0A01;
    chk("R6 flag not yet", lp_flag, 0);
    @(negedge clk); ma = 14'h0A02;
    @(negedge clk); ma = 14'h0A03;
    chk("R6 captured addr", lp_addr, 14'h0A02);
    chk("R6 flag set", lp_flag, 1);
    repeat (4) begin @(negedge clk); ma = ma + 1; end
    chk("R7 steady high", lp_addr, 14'h0A02);
    @(negedge clk); lp_rd = 1;
    @(negedge clk); lp_rd = 0;
    chk("R8 flag cleared", lp_flag, 0);
    chk("R8 addr kept", lp_addr, 14'h0A02);
    lpen = 0;
    repeat (5) begin @(negedge clk); ma = ma + 1; end
    chk("R7 falling addr", lp_addr, 14'h0A02);
    chk("R7 falling flag", lp_flag, 0);
    @(negedge clk); lpen = 1; ma = 14'h1500;
    @(negedge clk); ma = 14'h1501;
    @(negedge clk); ma = 14'h1502; lp_rd = 1;
    @(negedge clk); lp_rd = 0;
    chk("R8 set wins", lp_flag, 1);
    chk("R6 second capture", lp_addr, 14'h1502);
    lpen = 0;
  endtask

  initial begin
    #1 t_reset;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_cursor;
    t_pen;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #100000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule